// File: doc/BRIEF.md
# External Interrupt Front End

This block sits beside the execute stage of a small 32-bit processor and decides when an external interrupt exception is taken. It samples 32 level-sensitive request lines into a sticky pending register. It also holds a mask register, a two-bit enable register and an exception base register. Software reaches all four through a small control-register port with a two-bit select, a write strobe and a combinational read bus.

The pipeline raises a boundary strobe each time an instruction completes. In that cycle the block raises `take` if interrupts are live and at least one pending line is unmasked. While `take` is high, the block presents three things: the return address that the pipeline writes into general register 30, the redirected program counter, and the enable value that follows. An exception-return strobe restores the live enable bit from its saved copy.

Because pending bits are sticky, an interrupt that is blocked at one boundary is checked again at every later boundary. It is taken as soon as software unmasks it or enables interrupts.

Top module: `ext_irq_unit`

## Requirements
- R1: Request line `irq_req[i]`, for i from 0 to 31, drives pending bit i and no other bit.
- R2: A request line that is high at a clock edge sets its pending bit. The bit stays set after the line falls.
- R3: Writing the pending register clears every bit where the write data holds a 1 (write-one-to-clear). If a request line is high in the same cycle, its bit stays set.
- R4: `take` is 1 exactly when `boundary` is 1, enable bit 0 is 1, and the AND of the mask and pending registers is nonzero.
- R5: The low 8 bits of the base register always read as zero. On entry, `new_pc` equals the base plus 0xC0, which is exception ID 6 times 32.
- R6: While `take` is high, `ret_addr` equals `cur_pc`.
- R7: After a take, the enable register holds 2'b10. No second take follows in the next cycle.
- R8: An `eret` pulse without a take copies enable bit 1 into enable bit 0.
- R9: Reset clears the pending, mask, enable and base registers to zero.
- R10: The control-register select codes are: 0 for pending, 1 for mask, 2 for enable (data bits [1:0], upper bits read as zero) and 3 for base. Reads are combinational. If a take and a write to the enable register happen in the same cycle, the take wins.
- R11: No take happens without `boundary`. A pending line that becomes unmasked or enabled later is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Level interrupt request lines |
| boundary | input | 1 | Instruction-completion strobe |
| cur_pc | input | 32 | Program counter of the next instruction |
| eret | input | 1 | Exception-return strobe |
| csr_sel | input | 2 | Register select: 0 pending, 1 mask, 2 enable, 3 base |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the selected register |
| take | output | 1 | Interrupt exception taken this cycle |
| ret_addr | output | 32 | Return address for general register 30 |
| new_pc | output | 32 | Redirected program counter |
| ie_out | output | 2 | Enable register {saved, live} |

## Verification
The bench pulses each of the 32 lines on its own and drops it again. This catches a swapped or shared bit, and a pending bit that follows the line level instead of latching. It then runs write-one-to-clear in the same cycle as a high line; a design that let the clear win would lose that request. Every combination of enable, mask match and boundary is swept. A wrong take condition would either fire mid-instruction or ignore the mask. A base written with its low byte set must read back with that byte zeroed and vector to base+0xC0; a design that left the byte unaligned would jump to the wrong handler. The bench also checks that a masked pending line is taken once it is unmasked. Without sticky re-checking, that interrupt would never be taken.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int IRQ_LINES      = 32;
    localparam int WORD_W         = 32;
    localparam int IRQ_EXC_ID     = 6;
    localparam int VEC_STRIDE_LG2 = 5;
    localparam int BASE_ALIGN_LG2 = 8;

    typedef enum logic [1:0] {
        CSR_PEND = 2'd0,
        CSR_MASK = 2'd1,
        CSR_ENBL = 2'd2,
        CSR_BASE = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic saved;
        logic live;
    } ie_t;

    function automatic logic [WORD_W-1:0] vector_offset();
        return WORD_W'(IRQ_EXC_ID) << VEC_STRIDE_LG2;
    endfunction

    function automatic logic [WORD_W-1:0] align_base(input logic [WORD_W-1:0] raw);
        logic [WORD_W-1:0] keep;
        keep = {WORD_W{1'b1}} << BASE_ALIGN_LG2;
        return raw & keep;
    endfunction

endpackage

// File: rtl/ext_irq_pend.sv
module ext_irq_pend #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] pend_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
            end else if (req[i]) begin
                pend_q[i] <= 1'b1;          // set wins over clear
            end else if (clr_en && clr_bits[i]) begin
                pend_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ext_irq_enable.sv
module ext_irq_enable
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       eret,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output ie_t        ie_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
        end else if (take) begin
            ie_q.saved <= ie_q.live;
            ie_q.live  <= 1'b0;
        end else if (eret) begin
            ie_q.live  <= ie_q.saved;
        end else if (wr_en) begin
            ie_q <= ie_t'(wr_data);
        end
    end
endmodule

// File: rtl/ext_irq_decide.sv
module ext_irq_decide
    import ext_irq_pkg::*;
#(
    parameter int N = 32,
    parameter int W = 32
) (
    input  logic         boundary,
    input  logic         ie_live,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    input  logic [W-1:0] base,
    input  logic [W-1:0] cur_pc,
    output logic         take,
    output logic [W-1:0] ret_addr,
    output logic [W-1:0] new_pc
);
    logic [N-1:0] armed;

    always_comb begin
        armed    = pend & mask;
        take     = boundary && ie_live && (armed != '0);
        ret_addr = cur_pc;
        new_pc   = base + W'(vector_offset());
    end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int N = IRQ_LINES,
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_req,
    input  logic         boundary,
    input  logic [W-1:0] cur_pc,
    input  logic         eret,
    input  logic [1:0]   csr_sel,
    input  logic         csr_we,
    input  logic [W-1:0] csr_wdata,
    output logic [W-1:0] csr_rdata,
    output logic         take,
    output logic [W-1:0] ret_addr,
    output logic [W-1:0] new_pc,
    output logic [1:0]   ie_out
);
    csr_sel_e     sel;
    logic [N-1:0] pend_q;
    logic [N-1:0] mask_q;
    logic [W-1:0] base_q;
    ie_t          ie_q;
    logic [1:0]   ie_bits;

    assign sel     = csr_sel_e'(csr_sel);
    assign ie_bits = ie_q;
    assign ie_out  = ie_bits;

    ext_irq_pend #(.N(N)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .req      (irq_req),
        .clr_en   (csr_we && sel == CSR_PEND),
        .clr_bits (csr_wdata[N-1:0]),
        .pend_q   (pend_q)
    );

    ext_irq_enable u_ie (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .eret    (eret),
        .wr_en   (csr_we && sel == CSR_ENBL),
        .wr_data (csr_wdata[1:0]),
        .ie_q    (ie_q)
    );

    ext_irq_decide #(.N(N), .W(W)) u_dec (
        .boundary (boundary),
        .ie_live  (ie_q.live),
        .pend     (pend_q),
        .mask     (mask_q),
        .base     (base_q),
        .cur_pc   (cur_pc),
        .take     (take),
        .ret_addr (ret_addr),
        .new_pc   (new_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
        end else if (csr_we) begin
            if (sel == CSR_MASK) mask_q <= csr_wdata[N-1:0];
            if (sel == CSR_BASE) base_q <= align_base(csr_wdata);
        end
    end

    always_comb begin
        unique case (sel)
            CSR_PEND: csr_rdata = W'(pend_q);
            CSR_MASK: csr_rdata = W'(mask_q);
            CSR_ENBL: csr_rdata = W'(ie_bits);
            default:  csr_rdata = base_q;
        endcase
    end
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
    parameter int N = 32,
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] irq_req,
    input logic         boundary,
    input logic         eret,
    input logic         csr_we,
    input logic [1:0]   csr_sel,
    input logic         take,
    input logic [W-1:0] new_pc,
    input logic [1:0]   ie_bits,
    input logic [N-1:0] pend_q
);
    p_pend_set_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_req != '0) |=> ((pend_q & $past(irq_req)) == $past(irq_req)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !(csr_we && csr_sel == 2'd0) |=> (($past(pend_q) & ~pend_q) == '0));

    p_vector_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (new_pc[7:0] == 8'hC0));

    p_ie_entry_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (ie_bits == 2'b10));

    p_no_reentry_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    p_eret_r8: assert property (@(posedge clk) disable iff (rst)
        (eret && !take) |=> (ie_bits[0] == $past(ie_bits[1])));

    p_boundary_r11: assert property (@(posedge clk) disable iff (rst)
        !boundary |-> !take);
endmodule

bind ext_irq_unit ext_irq_unit_chk #(.N(N), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .boundary (boundary),
    .eret     (eret),
    .csr_we   (csr_we),
    .csr_sel  (csr_sel),
    .take     (take),
    .new_pc   (new_pc),
    .ie_bits  (ie_bits),
    .pend_q   (pend_q)
);

// File: tb/sim_ext_irq_unit.sv
module sim_ext_irq_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_req = '0;
    logic        boundary = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        eret = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        take;
    logic [31:0] ret_addr;
    logic [31:0] new_pc;
    logic [1:0]  ie_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_unit u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .boundary(boundary),
        .cur_pc(cur_pc), .eret(eret), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .take(take),
        .ret_addr(ret_addr), .new_pc(new_pc), .ie_out(ie_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        csr_sel = sel; csr_wdata = data; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        csr_sel = sel;
        #1;
        data = csr_rdata;
    endtask

    task automatic pulse_line(input int idx);
        @(negedge clk);
        irq_req[idx] = 1'b1;
        @(negedge clk);
        irq_req[idx] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state, R10 select codes
        rd(2'd0, v); chk("R9 pend", v, 32'h0);
        rd(2'd1, v); chk("R9 mask", v, 32'h0);
        rd(2'd2, v); chk("R9 enable", v, 32'h0);
        rd(2'd3, v); chk("R9 base", v, 32'h0);

        // R1 R2 R3 per-line sweep: set, stays after drop, W1C clears
        for (int i = 0; i < 32; i++) begin
            pulse_line(i);
            rd(2'd0, v); chk("R1 R2 line maps and sticks", v, 32'h1 << i);
            wr(2'd0, 32'h1 << i);
            rd(2'd0, v); chk("R3 w1c clears", v, 32'h0);
        end

        // R3 set wins over clear in same cycle
        @(negedge clk); irq_req[5] = 1'b1;
        wr(2'd0, 32'hFFFF_FFFF);
        irq_req[5] = 1'b0;
        rd(2'd0, v); chk("R3 set beats clear", v, 32'h20);
        wr(2'd0, 32'hFFFF_FFFF);

        // R5 base alignment and R10 mask readback
        wr(2'd3, 32'h1234_56FF);
        rd(2'd3, v); chk("R5 base low byte zero", v, 32'h1234_5600);
        wr(2'd1, 32'hA5A5_0F0F);
        rd(2'd1, v); chk("R10 mask readback", v, 32'hA5A5_0F0F);

        // R4 R6 R7 sweep over enable, mask match, boundary
        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 2; m++) begin
                for (int b = 0; b < 2; b++) begin
                    wr(2'd0, 32'hFFFF_FFFF);
                    pulse_line(9);
                    wr(2'd1, (m != 0) ? 32'h200 : ~32'h200);
                    wr(2'd2, (e != 0) ? 32'h1 : 32'h0);
                    @(negedge clk);
                    cur_pc = 32'h4000_0000 + 32'(e * 16 + m * 8 + b * 4);
                    boundary = (b != 0);
                    #1;
                    chk("R4 take condition", 32'(take), 32'((e & m & b) != 0));
                    if (take) begin
                        chk("R6 return address", ret_addr, cur_pc);
                        chk("R5 vector", new_pc, 32'h1234_56C0);
                    end
                    @(negedge clk);
                    boundary = 1'b0;
                    rd(2'd2, v);
                    chk("R7 enable after decision", v, ((e & m & b) != 0) ? 32'h2 : 32'(e));
                end
            end
        end

        // R8 eret restores live bit (enable is 2'b10 after last take)
        @(negedge clk); eret = 1'b1;
        @(negedge clk); eret = 1'b0;
        rd(2'd2, v); chk("R8 eret restores", v, 32'h3);

        // R10 take wins over enable write in same cycle
        @(negedge clk);
        boundary = 1'b1; csr_sel = 2'd2; csr_wdata = 32'h1; csr_we = 1'b1;
        #1; chk("R10 take fires", 32'(take), 32'h1);
        @(negedge clk);
        boundary = 1'b0; csr_we = 1'b0;
        rd(2'd2, v); chk("R10 take beats enable write", v, 32'h2);

        // R11 masked pending taken once unmasked later
        wr(2'd2, 32'h1);
        wr(2'd1, 32'h0);
        @(negedge clk); boundary = 1'b1; #1;
        chk("R11 masked no take", 32'(take), 32'h0);
        @(negedge clk); boundary = 1'b0;
        wr(2'd1, 32'h200);
        #1; chk("R11 no take without boundary", 32'(take), 32'h0);
        @(negedge clk); boundary = 1'b1; #1;
        chk("R11 unmasked later taken", 32'(take), 32'h1);
        @(negedge clk); boundary = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule